// File: doc/BRIEF.md
# Press Controller Configuration Register Bank with Pulse-Mode Lock

This block is the software-facing register bank of a button press controller. It holds the settings that the timing logic reads: the operating mode, a debounce code, a short-press code, a long-press code and an acknowledge-window code. It also holds the two press flags that the timing logic raises. Software reaches it through a plain address/data bus with separate read and write strobes. Read data is registered and appears one cycle after the read strobe.

Two registers are decoded. The control word sits at byte offset 0x50 and the flag word sits at 0x54. The control word also shows the live level of the button pin. Flags are cleared by writing 1 to them.

Choosing pulse mode locks the mode field for good and sends a single-cycle arm pulse towards the always-on domain. A system reset restores the defaults, but it leaves a locked mode alone. Only a power-on reset releases the lock.

Top module: `penable_cfg_regs`

## Requirements
- R1: After power-on reset the control word reads 0x0000_0001 with bit 18 equal to `pin_level`, the flag word reads 0, `mode_o` is 00, `dbc_code` is 001 and the other code outputs are 0.
- R2: A write to offset 0x50 stores the mode in bits 17:16, the acknowledge code in bits 13:12, the long-press code in bits 10:8, the short-press code in bits 6:4 and the debounce code in bits 2:0. All other bits read as 0. Read data is valid in the cycle after the read strobe.
- R3: Bit 18 of the control word always shows the current `pin_level`, and writes to it have no effect.
- R4: Mode code 00 selects level reset and 01 selects interrupt. Writing 10 or 11 enters pulse mode, after which the field reads 11 and `mode_o` is 11.
- R5: Once pulse mode is entered, writes to the mode field are ignored, while the four code fields stay writable.
- R6: `pulse_arm` is high for exactly one cycle, in the cycle after the write that enters pulse mode, and never again until the lock is released.
- R7: `rst_sys` clears the flags, restores the code fields to their reset values and sets the mode to 00, except that a locked mode stays 11. Only `rst_por` clears the lock.
- R8: In the flag word at offset 0x54, bit 0 is the short-press flag and bit 1 is the long-press flag. `sp_evt` and `lp_evt` set them. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R9: When a set event and a write-1 clear reach the same flag in the same cycle, the flag ends up set.
- R10: A read from any offset other than 0x50 and 0x54 returns 0, and a write to one changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_por | input | 1 | Synchronous active-high power-on reset; clears everything including the lock |
| rst_sys | input | 1 | Synchronous active-high system reset; keeps the pulse lock |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data, 0 when no mapped read |
| pin_level | input | 1 | Synchronized level of the button pin |
| sp_evt | input | 1 | Short-press set event from the timing logic |
| lp_evt | input | 1 | Long-press set event from the timing logic |
| mode_o | output | 2 | Current mode code |
| ack_code | output | 2 | Acknowledge-window code |
| lp_code | output | 3 | Long-press threshold code |
| sp_code | output | 3 | Short-press threshold code |
| dbc_code | output | 3 | Debounce time code |
| sp_flag | output | 1 | Short-press flag |
| lp_flag | output | 1 | Long-press flag |
| pulse_arm | output | 1 | One-cycle pulse on entry into pulse mode |

## Verification
The bench builds the block with its default parameters: an 8-bit byte address, a 32-bit data word and the two offsets 0x50 and 0x54. Because the decoder compares the full 8-bit address, an unmapped offset such as 0x60 is a real, reachable hole, so the zero read-back and the ignored write can both be seen at the ports. With 32-bit words, the reserved bits around each field can be written with ones and shown to read back as zeros. The same-cycle set and clear case, and the lock surviving a system reset but not a power-on reset, are both exercised.

// File: rtl/penable_pkg.sv
package penable_pkg;

  // Bit positions inside the control word (software decodes these).
  localparam int POS_DBC  = 0;
  localparam int POS_SP   = 4;
  localparam int POS_LP   = 8;
  localparam int POS_ACK  = 12;
  localparam int POS_MODE = 16;
  localparam int POS_PIN  = 18;

  localparam int ACK_W  = 2;
  localparam int LP_W   = 3;
  localparam int SP_W   = 3;
  localparam int DBC_W  = 3;
  localparam int MODE_W = 2;

  // Flag word bit positions.
  localparam int FLG_SP = 0;
  localparam int FLG_LP = 1;
  localparam int NUM_FLAGS = 2;

  localparam logic [MODE_W-1:0] MODE_LEVEL = 2'b00;
  localparam logic [MODE_W-1:0] MODE_IRQ   = 2'b01;
  localparam logic [MODE_W-1:0] MODE_PULSE = 2'b11;

  typedef struct packed {
    logic [ACK_W-1:0] ack;
    logic [LP_W-1:0]  lp;
    logic [SP_W-1:0]  sp;
    logic [DBC_W-1:0] dbc;
  } timing_codes_t;

  localparam timing_codes_t CODES_RST = '{ack: '0, lp: '0, sp: '0, dbc: 3'b001};

endpackage

// File: rtl/penable_decode.sv
module penable_decode #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFF = 8'h50,
  parameter logic [ADDR_W-1:0] FLAG_OFF = 8'h54
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic              ctrl_wr,
  output logic              flag_wr,
  output logic              ctrl_rd,
  output logic              flag_rd
);
  logic hit_ctrl;
  logic hit_flag;

  always_comb begin
    hit_ctrl = (addr == CTRL_OFF);
    hit_flag = (addr == FLAG_OFF);
    ctrl_wr  = wr_en & hit_ctrl;
    flag_wr  = wr_en & hit_flag;
    ctrl_rd  = rd_en & hit_ctrl;
    flag_rd  = rd_en & hit_flag;
  end
endmodule

// File: rtl/penable_ctrl_reg.sv
module penable_ctrl_reg
  import penable_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_por,
  input  logic                rst_sys,
  input  logic                wr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [MODE_W-1:0]   mode_q,
  output timing_codes_t       codes_q,
  output logic                arm_q
);
  logic                lock_q;
  logic [MODE_W-1:0]   wmode;
  timing_codes_t       wcodes;

  always_comb begin
    wmode      = wdata[POS_MODE +: MODE_W];
    wcodes.ack = wdata[POS_ACK  +: ACK_W];
    wcodes.lp  = wdata[POS_LP   +: LP_W];
    wcodes.sp  = wdata[POS_SP   +: SP_W];
    wcodes.dbc = wdata[POS_DBC  +: DBC_W];
  end

  always_ff @(posedge clk) begin
    if (rst_por) begin
      lock_q  <= 1'b0;
      mode_q  <= MODE_LEVEL;
      codes_q <= CODES_RST;
      arm_q   <= 1'b0;
    end else if (rst_sys) begin
      mode_q  <= lock_q ? MODE_PULSE : MODE_LEVEL;
      codes_q <= CODES_RST;
      arm_q   <= 1'b0;
    end else begin
      arm_q <= 1'b0;
      if (wr) begin
        codes_q <= wcodes;
        if (!lock_q) begin
          if (wmode[1]) begin
            lock_q <= 1'b1;
            mode_q <= MODE_PULSE;
            arm_q  <= 1'b1;
          end else begin
            mode_q <= wmode;
          end
        end
      end
    end
  end
endmodule

// File: rtl/penable_flag_reg.sv
module penable_flag_reg #(
  parameter int NUM = 2
) (
  input  logic           clk,
  input  logic           rst_por,
  input  logic           rst_sys,
  input  logic [NUM-1:0] set_evt,
  input  logic           clr_wr,
  input  logic [NUM-1:0] clr_mask,
  output logic [NUM-1:0] flag_q
);
  for (genvar i = 0; i < NUM; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst_por || rst_sys) begin
        flag_q[i] <= 1'b0;
      end else if (set_evt[i]) begin
        flag_q[i] <= 1'b1;           // set has priority over clear
      end else if (clr_wr && clr_mask[i]) begin
        flag_q[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/penable_rd_mux.sv
module penable_rd_mux
  import penable_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_por,
  input  logic                ctrl_rd,
  input  logic                flag_rd,
  input  logic                pin_level,
  input  logic [MODE_W-1:0]   mode,
  input  timing_codes_t       codes,
  input  logic [NUM_FLAGS-1:0] flags,
  output logic [DATA_W-1:0]   rdata
);
  logic [DATA_W-1:0] ctrl_word;
  logic [DATA_W-1:0] flag_word;
  logic [DATA_W-1:0] next_data;

  always_comb begin
    ctrl_word = '0;
    ctrl_word[POS_PIN]                = pin_level;
    ctrl_word[POS_MODE +: MODE_W]     = mode;
    ctrl_word[POS_ACK  +: ACK_W]      = codes.ack;
    ctrl_word[POS_LP   +: LP_W]       = codes.lp;
    ctrl_word[POS_SP   +: SP_W]       = codes.sp;
    ctrl_word[POS_DBC  +: DBC_W]      = codes.dbc;
    flag_word = '0;
    flag_word[NUM_FLAGS-1:0]          = flags;
    if (ctrl_rd)      next_data = ctrl_word;
    else if (flag_rd) next_data = flag_word;
    else              next_data = '0;
  end

  always_ff @(posedge clk) begin
    if (rst_por) rdata <= '0;
    else         rdata <= next_data;
  end
endmodule

// File: rtl/penable_cfg_regs.sv
module penable_cfg_regs
  import penable_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] CTRL_OFF = 8'h50,
  parameter logic [ADDR_W-1:0] FLAG_OFF = 8'h54
) (
  input  logic              clk,
  input  logic              rst_por,
  input  logic              rst_sys,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              pin_level,
  input  logic              sp_evt,
  input  logic              lp_evt,
  output logic [1:0]        mode_o,
  output logic [1:0]        ack_code,
  output logic [2:0]        lp_code,
  output logic [2:0]        sp_code,
  output logic [2:0]        dbc_code,
  output logic              sp_flag,
  output logic              lp_flag,
  output logic              pulse_arm
);
  logic                 ctrl_wr, flag_wr, ctrl_rd, flag_rd;
  timing_codes_t        codes;
  logic [NUM_FLAGS-1:0] set_vec;
  logic [NUM_FLAGS-1:0] flag_vec;

  penable_decode #(.ADDR_W(ADDR_W), .CTRL_OFF(CTRL_OFF), .FLAG_OFF(FLAG_OFF)) u_dec (
    .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .ctrl_wr(ctrl_wr), .flag_wr(flag_wr), .ctrl_rd(ctrl_rd), .flag_rd(flag_rd)
  );

  penable_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_por(rst_por), .rst_sys(rst_sys),
    .wr(ctrl_wr), .wdata(wdata),
    .mode_q(mode_o), .codes_q(codes), .arm_q(pulse_arm)
  );

  always_comb begin
    set_vec         = '0;
    set_vec[FLG_SP] = sp_evt;
    set_vec[FLG_LP] = lp_evt;
  end

  penable_flag_reg #(.NUM(NUM_FLAGS)) u_flags (
    .clk(clk), .rst_por(rst_por), .rst_sys(rst_sys),
    .set_evt(set_vec), .clr_wr(flag_wr), .clr_mask(wdata[NUM_FLAGS-1:0]),
    .flag_q(flag_vec)
  );

  penable_rd_mux #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_por(rst_por), .ctrl_rd(ctrl_rd), .flag_rd(flag_rd),
    .pin_level(pin_level), .mode(mode_o), .codes(codes), .flags(flag_vec),
    .rdata(rdata)
  );

  assign ack_code = codes.ack;
  assign lp_code  = codes.lp;
  assign sp_code  = codes.sp;
  assign dbc_code = codes.dbc;
  assign sp_flag  = flag_vec[FLG_SP];
  assign lp_flag  = flag_vec[FLG_LP];
endmodule

// File: rtl/penable_cfg_regs_chk.sv
module penable_cfg_regs_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] CTRL_OFF = 8'h50,
  parameter logic [ADDR_W-1:0] FLAG_OFF = 8'h54
) (
  input logic              clk,
  input logic              rst_por,
  input logic              rst_sys,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              sp_evt,
  input logic              lp_evt,
  input logic [1:0]        mode_o,
  input logic              sp_flag,
  input logic              lp_flag,
  input logic              pulse_arm
);
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst_por)
    (mode_o == 2'b11) |=> (mode_o == 2'b11)); // R5
  AST_ARM_SINGLE: assert property (@(posedge clk) disable iff (rst_por)
    pulse_arm |=> !pulse_arm); // R6
  AST_ARM_ON_ENTRY: assert property (@(posedge clk) disable iff (rst_por)
    pulse_arm |-> (mode_o == 2'b11) && ($past(mode_o) != 2'b11)); // R6
  AST_SYS_RST_MODE: assert property (@(posedge clk) disable iff (rst_por)
    (rst_sys && mode_o != 2'b11) |=> (mode_o == 2'b00)); // R7
  AST_SP_SET_WINS: assert property (@(posedge clk) disable iff (rst_por || rst_sys)
    sp_evt |=> sp_flag); // R9
  AST_LP_SET_WINS: assert property (@(posedge clk) disable iff (rst_por || rst_sys)
    lp_evt |=> lp_flag); // R9
  AST_LP_CLR_CAUSE: assert property (@(posedge clk) disable iff (rst_por)
    $fell(lp_flag) |-> $past(rst_sys || (wr_en && addr == FLAG_OFF && wdata[1]))); // R8
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst_por)
    (rd_en && addr != CTRL_OFF && addr != FLAG_OFF) |=> (rdata == '0)); // R10
endmodule

bind penable_cfg_regs penable_cfg_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_OFF(CTRL_OFF), .FLAG_OFF(FLAG_OFF)
) u_chk (
  .clk(clk), .rst_por(rst_por), .rst_sys(rst_sys), .wr_en(wr_en), .rd_en(rd_en),
  .addr(addr), .wdata(wdata), .rdata(rdata), .sp_evt(sp_evt), .lp_evt(lp_evt),
  .mode_o(mode_o), .sp_flag(sp_flag), .lp_flag(lp_flag), .pulse_arm(pulse_arm)
);

// File: tb/sim_penable_cfg_regs.sv
module sim_penable_cfg_regs;
  logic        clk = 1'b0;
  logic        rst_por = 1'b1, rst_sys = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pin_level = 1'b1, sp_evt = 1'b0, lp_evt = 1'b0;
  logic [1:0]  mode_o, ack_code;
  logic [2:0]  lp_code, sp_code, dbc_code;
  logic        sp_flag, lp_flag, pulse_arm;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk; // 125 MHz

  penable_cfg_regs u0 (
    .clk(clk), .rst_por(rst_por), .rst_sys(rst_sys), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .pin_level(pin_level),
    .sp_evt(sp_evt), .lp_evt(lp_evt), .mode_o(mode_o), .ack_code(ack_code),
    .lp_code(lp_code), .sp_code(sp_code), .dbc_code(dbc_code),
    .sp_flag(sp_flag), .lp_flag(lp_flag), .pulse_arm(pulse_arm)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  adr;
    logic [31:0] dat;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 11;
  // pin_level held at 1 throughout the table
  localparam vec_t VECS [0:NV-1] = '{
    '{1'b0, 8'h50, 32'h0,          32'h0004_0001, 4'd1},  // R1 reset read
    '{1'b1, 8'h50, 32'h0000_3777,  32'h0,         4'd2},
    '{1'b0, 8'h50, 32'h0,          32'h0004_3777, 4'd2},  // R2 all fields
    '{1'b1, 8'h50, 32'hFFFC_A5A5,  32'h0,         4'd2},
    '{1'b0, 8'h50, 32'h0,          32'h0004_2525, 4'd3},  // R3 bit18 not writable, reserved 0
    '{1'b1, 8'h50, 32'h0001_0001,  32'h0,         4'd4},
    '{1'b0, 8'h50, 32'h0,          32'h0005_0001, 4'd4},  // R4 interrupt mode
    '{1'b1, 8'h54, 32'h0000_0003,  32'h0,         4'd8},
    '{1'b0, 8'h54, 32'h0,          32'h0000_0000, 4'd8},  // R8 no flags
    '{1'b1, 8'h60, 32'hFFFF_FFFF,  32'h0,         4'd10},
    '{1'b0, 8'h60, 32'h0,          32'h0000_0000, 4'd10}  // R10 unmapped read
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic pulse_sys;
    @(negedge clk); rst_sys = 1'b1;
    @(posedge clk);
    @(negedge clk); rst_sys = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_por = 1'b0;
    // R1 reset outputs
    chk(mode_o == 2'b00 && dbc_code == 3'b001 && ack_code == 0 && lp_code == 0
        && sp_code == 0 && !sp_flag && !lp_flag && !pulse_arm, "R1 reset outputs",
        {mode_o, ack_code, lp_code, sp_code, dbc_code}, 32'h0000_0001);
    rd(8'h54, v); chk(v == 0, "R1 flag word", v, 0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) wr(VECS[i].adr, VECS[i].dat);
      else begin
        rd(VECS[i].adr, v);
        chk(v == VECS[i].exp, $sformatf("R%0d table row %0d", VECS[i].req, i), v, VECS[i].exp);
      end
    end
    // R10 write to 0x60 left control intact
    rd(8'h50, v); chk(v == 32'h0005_0001, "R10 unmapped write no effect", v, 32'h0005_0001);
    chk(mode_o == 2'b01, "R4 interrupt mode output", mode_o, 2'b01);

    // R3 pin low
    pin_level = 1'b0;
    rd(8'h50, v); chk(v == 32'h0001_0001, "R3 pin low", v, 32'h0001_0001);
    pin_level = 1'b1;

    // R8 flag set and clear
    @(negedge clk); sp_evt = 1'b1; @(negedge clk); sp_evt = 1'b0;
    rd(8'h54, v); chk(v == 32'h1, "R8 short flag set", v, 32'h1);
    @(negedge clk); lp_evt = 1'b1; @(negedge clk); lp_evt = 1'b0;
    rd(8'h54, v); chk(v == 32'h3, "R8 long flag set", v, 32'h3);
    wr(8'h54, 32'h0);
    rd(8'h54, v); chk(v == 32'h3, "R8 write 0 no effect", v, 32'h3);
    wr(8'h54, 32'h1);
    rd(8'h54, v); chk(v == 32'h2, "R8 write 1 clears bit0", v, 32'h2);
    // R9 set and clear same cycle
    @(negedge clk); wr_en = 1'b1; addr = 8'h54; wdata = 32'h2; lp_evt = 1'b1;
    @(posedge clk);
    @(negedge clk); wr_en = 1'b0; wdata = '0; lp_evt = 1'b0;
    rd(8'h54, v); chk(v == 32'h2, "R9 set wins", v, 32'h2);
    wr(8'h54, 32'h2);
    rd(8'h54, v); chk(v == 32'h0, "R8 long flag cleared", v, 32'h0);

    // R7 system reset while unlocked
    wr(8'h50, 32'h0001_3777);
    @(negedge clk); sp_evt = 1'b1; @(negedge clk); sp_evt = 1'b0;
    pulse_sys();
    chk(mode_o == 2'b00 && !sp_flag, "R7 sys reset mode and flag", {sp_flag, mode_o}, 0);
    rd(8'h50, v); chk(v == 32'h0004_0001, "R7 sys reset control", v, 32'h0004_0001);

    // R4 R6 enter pulse mode with code 10
    wr(8'h50, 32'h0002_0000);
    chk(pulse_arm == 1'b1, "R6 arm pulse high", pulse_arm, 1);
    @(negedge clk);
    chk(pulse_arm == 1'b0, "R6 arm pulse one cycle", pulse_arm, 0);
    chk(mode_o == 2'b11, "R4 pulse mode output", mode_o, 2'b11);
    rd(8'h50, v); chk(v == 32'h0007_0000, "R4 pulse reads 11", v, 32'h0007_0000);

    // R5 lock ignores mode, fields writable
    wr(8'h50, 32'h0000_0123);
    rd(8'h50, v); chk(v == 32'h0007_0123, "R5 mode locked fields written", v, 32'h0007_0123);
    wr(8'h50, 32'h0003_0000);
    chk(pulse_arm == 1'b0, "R6 no second arm pulse", pulse_arm, 0);

    // R7 system reset keeps lock
    pulse_sys();
    rd(8'h50, v); chk(v == 32'h0007_0001, "R7 lock survives sys reset", v, 32'h0007_0001);
    wr(8'h50, 32'h0000_0000);
    chk(mode_o == 2'b11, "R5 still locked after sys reset", mode_o, 2'b11);

    // R7 power-on reset releases lock
    @(negedge clk); rst_por = 1'b1;
    @(posedge clk);
    @(negedge clk); rst_por = 1'b0;
    rd(8'h50, v); chk(v == 32'h0004_0001, "R7 por clears lock", v, 32'h0004_0001);
    wr(8'h50, 32'h0001_0000);
    chk(mode_o == 2'b01, "R7 mode writable after por", mode_o, 2'b01);

    finish_run();
  end
endmodule